// File: doc/BRIEF.md
# 64b/66b Block to XGMII Decoder

This block sits on the receive side of a 10 Gb/s BASE-R physical coding path. Upstream logic has already found block lock and descrambled the stream. This block takes one block: a 2-bit sync header and a 64-bit payload. It turns the block back into one 8-lane XGMII word, made of eight data bytes and eight control flags.

The block covers every legal block type. These include plain data blocks and all-control blocks, Start in lane 0 or lane 4, the ordered-set forms, and Terminate in any of the eight lanes. Control characters arrive as 7-bit codes and are widened back to 8-bit XGMII characters. An ordered-set code arrives as a 4-bit nibble and is turned into the sequence or signal character.

A block that cannot be decoded does not pass through. This covers a bad sync header and an unknown block type. Such a block is replaced by error characters on all eight lanes, and a one-cycle error flag is raised. The output is registered and advances only when the clock enable is high, so the block can follow a gearbox that produces a block on some cycles only.

Top module: `xgmii_block_decoder`

## Requirements
- R1: A sync header of 01 (data) puts payload byte i on lane i for all eight lanes. All control flags are 0 and the error flag is 0.
- R2: A lane that takes a control code reads the 7 payload bits starting at bit 8+7i. The code is mapped as follows: 0x00→0x07, 0x06→0x06, 0x1E→0xFE, 0x2D→0x1C, 0x33→0x3C, 0x4B→0x7C, 0x55→0xBC, 0x66→0xDC, 0x78→0xF7. Every other code becomes 0xFE.
- R3: Sync header 10 with type byte (payload bits 7:0) 0x1E gives the mapped control codes on all eight lanes, with all control flags set.
- R4: Type 0x78 gives Start (0xFB, control) on lane 0 and payload bytes 1..7 as data on lanes 1..7. Type 0x33 gives control codes on lanes 0..3, Start on lane 4, and payload bytes 5..7 as data on lanes 5..7.
- R5: The lane-0 ordered-set nibble is payload bits 35:32. The lane-4 ordered-set nibble is payload bits 39:36. Nibble 0x0 gives 0x9C, nibble 0xF gives 0x5C, and any other nibble gives 0xFE. The lane is always marked control, and this holds for every block type that carries the nibble.
- R6: Type 0x66 gives the lane-0 ordered set, data bytes 1..3 on lanes 1..3, Start on lane 4 and data bytes 5..7 on lanes 5..7. Type 0x55 gives the same layout, except that lane 4 carries the lane-4 ordered set instead of Start.
- R7: Type 0x4B gives the lane-0 ordered set, data bytes 1..3 on lanes 1..3, and control codes on lanes 4..7. Type 0x2D gives control codes on lanes 0..3, the lane-4 ordered set on lane 4, and data bytes 5..7 on lanes 5..7.
- R8: Each Terminate type marks one lane k: 0x87→0, 0x99→1, 0xAA→2, 0xB4→3, 0xCC→4, 0xD2→5, 0xE1→6, 0xFF→7. Lanes below k carry payload bytes 1..k as data. Lane k carries Terminate (0xFD, control). Lanes above k carry their control codes.
- R9: A sync header of 00 or 11, or header 10 with any other type byte, gives 0xFE on all lanes with all control flags set and the error flag at 1. Every valid block leaves the error flag at 0.
- R10: The outputs update one clock edge after an edge where the enable is high. They hold their value at every edge where the enable is low.
- R11: While reset is high, every lane holds 0x07 with its control flag set, and the error flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; a block is taken when high |
| blk_hdr | input | 2 | Sync header of the incoming block |
| blk_payload | input | 64 | Descrambled block payload, type byte in bits 7:0 |
| lane_data | output | 64 | XGMII data, lane i in bits 8i+7:8i |
| lane_ctrl | output | 8 | XGMII control flag per lane |
| blk_err | output | 1 | High for the output word decoded from an invalid block |

## Verification
The decoder has no size parameters: the lane count and code widths are fixed by the line code. Because the configuration is this small, the bench can sweep every input class in full. It covers all 256 type bytes under the control header with several payloads each, all 128 control codes in every lane, and every pair of ordered-set nibbles. It also covers all four sync header values. Each result is compared against a lane-by-lane model written from the requirements. The clock enable is exercised by changing the inputs while the enable is low and confirming that the previous word is held.

// File: rtl/xgmii_block_decoder.sv
module xgmii_block_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        ce,
  input  logic [1:0]  blk_hdr,
  input  logic [63:0] blk_payload,
  output logic [63:0] lane_data,
  output logic [7:0]  lane_ctrl,
  output logic        blk_err
);
  localparam int LANES = 8;
  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;

  function automatic logic [7:0] map_code(input logic [6:0] c);
    case (c)
      7'h00:   return 8'h07;
      7'h06:   return 8'h06;
      7'h1E:   return 8'hFE;
      7'h2D:   return 8'h1C;
      7'h33:   return 8'h3C;
      7'h4B:   return 8'h7C;
      7'h55:   return 8'hBC;
      7'h66:   return 8'hDC;
      7'h78:   return 8'hF7;
      default: return CH_ERR;
    endcase
  endfunction

  function automatic logic [7:0] map_onib(input logic [3:0] n);
    case (n)
      4'h0:    return 8'h9C;
      4'hF:    return 8'h5C;
      default: return CH_ERR;
    endcase
  endfunction

  logic [LANES-1:0][7:0] ccode;
  logic [LANES-1:0][7:0] nd;
  logic [LANES-1:0]      nc;
  logic                  bad;
  logic                  is_term;
  logic [2:0]            tlane;
  logic [7:0]            btype;
  logic [7:0]            o_lo, o_hi;
  logic [63:0]           shifted;

  for (genvar g = 0; g < LANES; g++) begin : g_code
    assign ccode[g] = map_code(blk_payload[8+7*g +: 7]);
  end

  assign btype   = blk_payload[7:0];
  assign o_lo    = map_onib(blk_payload[35:32]);
  assign o_hi    = map_onib(blk_payload[39:36]);
  assign shifted = {8'h00, blk_payload[63:8]};

  always_comb begin
    is_term = 1'b1;
    tlane   = 3'd0;
    case (btype)
      8'h87: tlane = 3'd0;
      8'h99: tlane = 3'd1;
      8'hAA: tlane = 3'd2;
      8'hB4: tlane = 3'd3;
      8'hCC: tlane = 3'd4;
      8'hD2: tlane = 3'd5;
      8'hE1: tlane = 3'd6;
      8'hFF: tlane = 3'd7;
      default: is_term = 1'b0;
    endcase
  end

  always_comb begin
    nd  = {LANES{CH_ERR}};
    nc  = '1;
    bad = 1'b1;
    if (blk_hdr == HDR_DATA) begin
      nd  = blk_payload;
      nc  = '0;
      bad = 1'b0;
    end else if (blk_hdr == HDR_CTRL) begin
      bad = 1'b0;
      case (btype)
        8'h1E: begin nd = ccode; nc = 8'hFF; end
        8'h78: begin nd = {shifted[55:0], CH_START}; nc = 8'h01; end
        8'h33: begin nd = {blk_payload[63:40], CH_START, ccode[3], ccode[2], ccode[1], ccode[0]}; nc = 8'h1F; end
        8'h66: begin nd = {blk_payload[63:40], CH_START, blk_payload[31:8], o_lo}; nc = 8'h11; end
        8'h55: begin nd = {blk_payload[63:40], o_hi, blk_payload[31:8], o_lo}; nc = 8'h11; end
        8'h4B: begin nd = {ccode[7], ccode[6], ccode[5], ccode[4], blk_payload[31:8], o_lo}; nc = 8'hF1; end
        8'h2D: begin nd = {blk_payload[63:40], o_hi, ccode[3], ccode[2], ccode[1], ccode[0]}; nc = 8'h1F; end
        default: begin
          if (is_term) begin
            for (int j = 0; j < LANES; j++) begin
              if (j < int'(tlane)) begin
                nd[j] = shifted[8*j +: 8];
                nc[j] = 1'b0;
              end else if (j == int'(tlane)) begin
                nd[j] = CH_TERM;
                nc[j] = 1'b1;
              end else begin
                nd[j] = ccode[j];
                nc[j] = 1'b1;
              end
            end
          end else begin
            bad = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_data <= {LANES{CH_IDLE}};
      lane_ctrl <= '1;
      blk_err   <= 1'b0;
    end else if (ce) begin
      lane_data <= nd;
      lane_ctrl <= nc;
      blk_err   <= bad;
    end
  end

  assert_data_hdr_R1: assert property (@(posedge clk) disable iff (rst)
    (ce && blk_hdr == HDR_DATA) |=> (lane_ctrl == 8'h00 && !blk_err && lane_data == $past(blk_payload)));

  assert_bad_hdr_R9: assert property (@(posedge clk) disable iff (rst)
    (ce && (blk_hdr == 2'b00 || blk_hdr == 2'b11)) |=> (blk_err && lane_ctrl == 8'hFF && lane_data == {LANES{CH_ERR}}));

  assert_err_all_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    blk_err |-> (lane_ctrl == 8'hFF));

  assert_start0_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && blk_hdr == HDR_CTRL && blk_payload[7:0] == 8'h78) |=> (lane_ctrl == 8'h01 && lane_data[7:0] == CH_START));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(lane_data) && $stable(lane_ctrl) && $stable(blk_err)));
endmodule

// File: tb/xgmii_block_decoder_tb.sv
module xgmii_block_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic [1:0]  blk_hdr = 2'b00;
  logic [63:0] blk_payload = '0;
  logic [63:0] lane_data;
  logic [7:0]  lane_ctrl;
  logic        blk_err;
  int checks = 0;
  int failures = 0;
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

  always #2.5 clk = ~clk;

  xgmii_block_decoder u_dut (
    .clk(clk), .rst(rst), .ce(ce), .blk_hdr(blk_hdr), .blk_payload(blk_payload),
    .lane_data(lane_data), .lane_ctrl(lane_ctrl), .blk_err(blk_err)
  );

  function automatic logic [7:0] m7(input logic [6:0] c);
    logic [7:0] r;
    r = 8'hFE;
    if (c == 7'h00) r = 8'h07;
    if (c == 7'h06) r = 8'h06;
    if (c == 7'h2D) r = 8'h1C;
    if (c == 7'h33) r = 8'h3C;
    if (c == 7'h4B) r = 8'h7C;
    if (c == 7'h55) r = 8'hBC;
    if (c == 7'h66) r = 8'hDC;
    if (c == 7'h78) r = 8'hF7;
    return r;
  endfunction

  function automatic logic [7:0] mo(input logic [3:0] n);
    return (n == 4'h0) ? 8'h9C : (n == 4'hF) ? 8'h5C : 8'hFE;
  endfunction

  // returns {err, ctrl, data}
  function automatic logic [72:0] model(input logic [1:0] h, input logic [63:0] p);
    logic [7:0][7:0] d;
    logic [7:0] c;
    logic e;
    int k;
    logic [7:0] t;
    t = p[7:0];
    d = {8{8'hFE}}; c = 8'hFF; e = 1'b1;
    k = -1;
    case (t)
      8'h87: k = 0; 8'h99: k = 1; 8'hAA: k = 2; 8'hB4: k = 3;
      8'hCC: k = 4; 8'hD2: k = 5; 8'hE1: k = 6; 8'hFF: k = 7;
      default: k = -1;
    endcase
    if (h == 2'b01) begin
      for (int i = 0; i < 8; i++) begin d[i] = p[8*i +: 8]; c[i] = 1'b0; end
      e = 1'b0;
    end else if (h == 2'b10) begin
      e = 1'b0;
      for (int i = 0; i < 8; i++) begin
        if (i == 0 && (t == 8'h66 || t == 8'h55 || t == 8'h4B)) begin d[i] = mo(p[35:32]); c[i] = 1; end
        else if (i == 4 && (t == 8'h55 || t == 8'h2D)) begin d[i] = mo(p[39:36]); c[i] = 1; end
        else if ((i == 0 && t == 8'h78) || (i == 4 && (t == 8'h33 || t == 8'h66))) begin d[i] = 8'hFB; c[i] = 1; end
        else if (t == 8'h1E || (i < 4 && (t == 8'h33 || t == 8'h2D)) || (i > 3 && t == 8'h4B)) begin
          d[i] = m7(p[8+7*i +: 7]); c[i] = 1;
        end else if (t == 8'h78 || t == 8'h33 || t == 8'h66 || t == 8'h55 || t == 8'h4B || t == 8'h2D) begin
          d[i] = p[8*i +: 8]; c[i] = 0;
        end else if (k >= 0) begin
          if (i < k) begin d[i] = p[8*(i+1) +: 8]; c[i] = 0; end
          else if (i == k) begin d[i] = 8'hFD; c[i] = 1; end
          else begin d[i] = m7(p[8+7*i +: 7]); c[i] = 1; end
        end else begin
          e = 1'b1;
        end
      end
      if (e) begin d = {8{8'hFE}}; c = 8'hFF; end
    end
    return {e, c, d};
  endfunction

  function automatic string tag_of(input logic [1:0] h, input logic [7:0] t);
    if (h != 2'b10) return (h == 2'b01) ? "R1" : "R9";
    case (t)
      8'h1E: return "R3";
      8'h78, 8'h33: return "R4";
      8'h66, 8'h55: return "R6";
      8'h4B, 8'h2D: return "R7";
      8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    return x ^ (x << 17);
  endfunction

  task automatic check(input logic [72:0] exp, input string r);
    checks++;
    if ({blk_err, lane_ctrl, lane_data} !== exp) begin
      failures++;
      $display("FAIL %s: got err=%0b ctrl=%02h data=%016h exp err=%0b ctrl=%02h data=%016h",
               r, blk_err, lane_ctrl, lane_data, exp[72], exp[71:64], exp[63:0]);
    end
  endtask

  task automatic run(input logic [1:0] h, input logic [63:0] p, input string r);
    blk_hdr = h; blk_payload = p; ce = 1'b1;
    @(posedge clk); @(negedge clk);
    check(model(h, p), r);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [72:0] held;
    repeat (3) @(negedge clk);
    check({1'b0, 8'hFF, {8{8'h07}}}, "R11");
    rst = 1'b0;
    // R1: data header with varied payloads
    for (int i = 0; i < 16; i++) begin seed = nxt(seed); run(2'b01, seed, "R1"); end
    run(2'b01, 64'hFBFD_FE07_9C5C_0000, "R1");
    // R2 / R3: every 7-bit code in every lane
    for (int c = 0; c < 128; c++) begin
      logic [63:0] p;
      p = {{8{c[6:0]}}, 8'h1E};
      run(2'b10, p, "R2");
    end
    // R4..R9: every type byte, several payloads
    for (int t = 0; t < 256; t++) begin
      for (int n = 0; n < 4; n++) begin
        seed = nxt(seed);
        run(2'b10, {seed[63:8], t[7:0]}, tag_of(2'b10, t[7:0]));
      end
    end
    // R5: every ordered-set nibble pair, all carrying types
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        seed = nxt(seed);
        run(2'b10, {seed[63:40], b[3:0], a[3:0], seed[31:8], 8'h55}, "R5");
      end
      seed = nxt(seed);
      run(2'b10, {seed[63:36], a[3:0], seed[31:8], 8'h4B}, "R5");
      run(2'b10, {seed[63:36], a[3:0], seed[31:8], 8'h66}, "R5");
      run(2'b10, {seed[63:40], a[3:0], seed[35:8], 8'h2D}, "R5");
    end
    // R9: invalid headers
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed);
      run(2'b00, seed, "R9");
      run(2'b11, {seed[63:8], 8'h1E}, "R9");
    end
    // R10: enable low holds the previous word
    run(2'b10, 64'h0000_0000_0000_0078, "R10");
    held = model(2'b10, 64'h0000_0000_0000_0078);
    ce = 1'b0;
    for (int i = 0; i < 4; i++) begin
      seed = nxt(seed);
      blk_hdr = 2'b00; blk_payload = seed;
      @(posedge clk); @(negedge clk);
      check(held, "R10");
    end
    run(2'b01, 64'hA5A5_5A5A_1234_5678, "R10");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check({1'b0, 8'hFF, {8{8'h07}}}, "R11");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule